// File: doc/BRIEF.md
# Serial-Bus Page Programmer for an On-Chip Non-Volatile Store

This block is an I2C target that fronts a 256-byte non-volatile store arranged as sixteen pages of sixteen bytes. The first byte of each command is a control byte. Its top four bits must match a parameter code, its next three bits select a block, and its lowest bit gives the direction. A write command then carries a word address and a run of data bytes. The data bytes are gathered in a page buffer. Nothing reaches the store until the master sends Stop, and then only if exactly a full page of sixteen bytes arrived.

That Stop launches a self-timed commit that lasts `WR_CYCLES` clocks. `nvm_busy` is high for the whole commit. During it the bus logic keeps running, but it refuses any command aimed at the store, so a master can poll with control bytes until one is acknowledged. To read, the master writes the word address, sends a repeated Start, and then a control byte with the read bit set. The target then streams bytes from the address counter for as long as the master acknowledges them.

SCL and SDA arrive already synchronised to `clk`. The target pulls SDA low by raising `sda_oe`.

Top module: `nvm_page_prog`

## Requirements
- R1: A Start is SDA falling while SCL is high. A Stop is SDA rising while SCL is high. Each bit of a byte is sampled on the rising edge of SCL, most significant bit first. A Start, repeated or not, always begins a new command.
- R2: Control byte layout: bits [7:4] hold the code, which must equal `CTRL_CODE` (default 4'b1010). Bits [3:1] hold the block number, which must be 3'b000. Bit [0] is the direction (0 = write, 1 = read). A control byte that fails either test is not acknowledged, and every later byte is also left unacknowledged until the next Start.
- R3: For an accepted control byte, word address byte or data byte, the target holds SDA low for the whole ninth clock. It changes its SDA drive only while SCL is low.
- R4: The word address is split into two fields. Bits [7:4] select the page and bits [3:0] give the starting offset. Successive data bytes land at offsets that wrap modulo 16 inside that page. Sixteen data bytes are acknowledged; a seventeenth is not.
- R5: A commit starts only at a Stop that ends a write command holding exactly sixteen data bytes. A Stop after fewer bytes leaves the store unchanged and `nvm_busy` low.
- R6: `nvm_busy` rises on the clock after the committing Stop is sampled and stays high for exactly `WR_CYCLES` clocks. The new page is readable afterwards.
- R7: While `nvm_busy` is high, a control byte that would otherwise be accepted is not acknowledged.
- R8: A repeated Start after the word address drops the write without a commit, but the word address stays loaded in the address counter.
- R9: A read control byte is acknowledged. The target then sends the byte at the address counter, MSB first. Each master ACK advances the counter by one, wrapping at 256 across page boundaries, and sends the next byte. A master NACK releases SDA.
- R10: After reset, `sda_oe` and `nvm_busy` are low, the address counter is 0, and every store byte reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line |
| sda_oe | output | 1 | Pull SDA low when high (open drain) |
| nvm_busy | output | 1 | Self-timed commit in progress |

## Verification
The hardest state to reach is a control byte that arrives while a commit is still running. The bench reaches it by sending a full sixteen-byte page and its Stop, then a new Start and control byte at once, well inside the shortened commit time. The repeated-Start path is driven the same way a real master would drive it. Every read goes through a write of the word address followed by a repeated Start. A read that runs past the end of a page shows that the counter crosses into the next page. A behavioural model predicts `nvm_busy` and is compared against it on every clock.

// File: rtl/nvmp_pkg.sv
`timescale 1ns/1ps
package nvmp_pkg;
    localparam int BYTE_W     = 8;
    localparam int OFF_W      = 4;
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int WADDR_W    = 8;
    localparam int PAGE_W     = WADDR_W - OFF_W;
    localparam int NUM_PAGES  = 1 << PAGE_W;
    localparam int CNT_W      = OFF_W + 1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [PAGE_BYTES-1:0][BYTE_W-1:0] page_t;

    typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} bus_st_e;
    typedef enum logic [1:0] {PH_CTRL, PH_ADDR, PH_DATA} phase_e;

    typedef struct packed {
        logic [3:0] code;
        logic [2:0] block;
        logic       rnw;
    } ctrl_t;

    function automatic logic ctrl_hit(ctrl_t c, logic [3:0] want);
        return (c.code == want) && (c.block == 3'b000);
    endfunction
endpackage

// File: rtl/nvmp_line_mon.sv
`timescale 1ns/1ps
module nvmp_line_mon (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise = scl_i & ~scl_q;
    assign scl_fall = ~scl_i & scl_q;
    assign start_c  = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_c   = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/nvmp_commit_timer.sv
`timescale 1ns/1ps
module nvmp_commit_timer #(
    parameter int unsigned CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            left <= '0;
        end else if (busy) begin
            if (left == '0) busy <= 1'b0;
            else            left <= left - 1'b1;
        end else if (go) begin
            busy <= 1'b1;
            left <= CW'(CYCLES - 1);
        end
    end

    assign done = busy && (left == '0);
endmodule

// File: rtl/nvmp_store.sv
`timescale 1ns/1ps
module nvmp_store
    import nvmp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [WADDR_W-1:0] rd_addr,
    output byte_t              rd_data,
    input  logic               wr_en,
    input  logic [PAGE_W-1:0]  wr_page,
    input  page_t              wr_data
);
    page_t mem [NUM_PAGES];

    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_PAGES; p++) begin
            if (rst)
                mem[p] <= '1;
            else if (wr_en && (wr_page == PAGE_W'(p)))
                mem[p] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr[WADDR_W-1:OFF_W]][rd_addr[OFF_W-1:0]];
endmodule

// File: rtl/nvm_page_prog.sv
`timescale 1ns/1ps
module nvm_page_prog
    import nvmp_pkg::*;
#(
    parameter logic [3:0]  CTRL_CODE = 4'b1010,
    parameter int unsigned WR_CYCLES = 2_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic nvm_busy
);
    logic scl_rise, scl_fall, start_c, stop_c;
    bus_st_e            st;
    phase_e             ph;
    logic [3:0]         bitcnt;
    byte_t              shreg;
    logic [WADDR_W-1:0] addr;
    logic               wr_open, go_tx, mack_ok;
    logic [CNT_W-1:0]   wr_cnt;
    page_t              pbuf;
    logic [PAGE_W-1:0]  cpage;
    logic               commit_go, commit_done, page_full;
    byte_t              rd_data;
    ctrl_t              rx_ctrl;

    nvmp_line_mon u_mon (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_c(start_c), .stop_c(stop_c)
    );

    nvmp_commit_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .go(commit_go),
        .busy(nvm_busy), .done(commit_done)
    );

    nvmp_store u_store (
        .clk(clk), .rst(rst), .rd_addr(addr), .rd_data(rd_data),
        .wr_en(commit_done), .wr_page(cpage), .wr_data(pbuf)
    );

    assign rx_ctrl   = ctrl_t'(shreg);
    assign page_full = (wr_cnt == CNT_W'(PAGE_BYTES));
    assign commit_go = stop_c && wr_open && page_full && !nvm_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            ph      <= PH_CTRL;
            bitcnt  <= '0;
            shreg   <= '0;
            addr    <= '0;
            wr_open <= 1'b0;
            wr_cnt  <= '0;
            go_tx   <= 1'b0;
            mack_ok <= 1'b0;
            sda_oe  <= 1'b0;
            pbuf    <= '1;
            cpage   <= '0;
        end else begin
            if (commit_go) cpage <= addr[WADDR_W-1:OFF_W];
            if (start_c) begin
                st      <= S_RX;
                ph      <= PH_CTRL;
                bitcnt  <= '0;
                sda_oe  <= 1'b0;
                wr_open <= 1'b0;
            end else if (stop_c) begin
                st      <= S_IDLE;
                sda_oe  <= 1'b0;
                wr_open <= 1'b0;
            end else begin
                unique case (st)
                    S_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_i};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            unique case (ph)
                                PH_CTRL: begin
                                    if (ctrl_hit(rx_ctrl, CTRL_CODE) && !nvm_busy) begin
                                        sda_oe <= 1'b1;
                                        st     <= S_ACK;
                                        go_tx  <= rx_ctrl.rnw;
                                        ph     <= PH_ADDR;
                                    end else begin
                                        st <= S_IDLE;
                                    end
                                end
                                PH_ADDR: begin
                                    sda_oe  <= 1'b1;
                                    st      <= S_ACK;
                                    go_tx   <= 1'b0;
                                    addr    <= shreg;
                                    wr_open <= 1'b1;
                                    wr_cnt  <= '0;
                                    ph      <= PH_DATA;
                                end
                                default: begin
                                    if (!page_full) begin
                                        sda_oe <= 1'b1;
                                        st     <= S_ACK;
                                        go_tx  <= 1'b0;
                                        pbuf[addr[OFF_W-1:0]]  <= shreg;
                                        addr[OFF_W-1:0] <= addr[OFF_W-1:0] + 1'b1;
                                        wr_cnt <= wr_cnt + 1'b1;
                                    end else begin
                                        st <= S_IDLE;
                                    end
                                end
                            endcase
                        end
                    end
                    S_ACK: begin
                        if (scl_fall) begin
                            if (go_tx) begin
                                sda_oe <= ~rd_data[BYTE_W-1];
                                shreg  <= {rd_data[BYTE_W-2:0], 1'b0};
                                bitcnt <= '0;
                                st     <= S_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= S_RX;
                            end
                        end
                    end
                    S_TX: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                st     <= S_MACK;
                            end else begin
                                sda_oe <= ~shreg[BYTE_W-1];
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    S_MACK: begin
                        if (scl_rise) begin
                            mack_ok <= ~sda_i;
                            if (!sda_i) addr <= addr + 1'b1;
                        end else if (scl_fall) begin
                            if (mack_ok) begin
                                sda_oe <= ~rd_data[BYTE_W-1];
                                shreg  <= {rd_data[BYTE_W-2:0], 1'b0};
                                bitcnt <= '0;
                                st     <= S_TX;
                            end else begin
                                st <= S_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/nvmp_checks.sv
`timescale 1ns/1ps
module nvmp_checks
    import nvmp_pkg::*;
#(
    parameter int unsigned WR_CYCLES = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             scl_i,
    input logic             sda_oe,
    input logic             nvm_busy,
    input logic             stop_c,
    input logic [CNT_W-1:0] wr_cnt
);
    logic [31:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst)           busy_len <= '0;
        else if (nvm_busy) busy_len <= busy_len + 1'b1;
        else               busy_len <= '0;
    end

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_i); // R3

    AST_WCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        wr_cnt <= CNT_W'(PAGE_BYTES)); // R4

    AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(nvm_busy) |-> $past(stop_c)); // R5

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(nvm_busy) |-> busy_len == WR_CYCLES); // R6
endmodule

bind nvm_page_prog nvmp_checks #(.WR_CYCLES(WR_CYCLES)) u_checks (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
    .nvm_busy(nvm_busy), .stop_c(stop_c), .wr_cnt(wr_cnt)
);

// File: tb/nvm_page_prog_test.sv
`timescale 1ns/1ps
module nvm_page_prog_test;
    localparam int WRC = 400;
    localparam logic [7:0] CW = 8'hA0;
    localparam logic [7:0] CR = 8'hA1;

    logic clk = 1'b0, rst = 1'b1, m_scl = 1'b1, m_sda = 1'b1;
    logic sda_oe, nvm_busy, sda_bus;
    int n_run = 0, n_fail = 0;
    logic [7:0] mdl [256];
    int arm_cnt = 0, arm_seen = 0, left = 0;
    bit finished = 0;

    always #4 clk = ~clk;
    assign sda_bus = m_sda & ~sda_oe;

    nvm_page_prog #(.CTRL_CODE(4'b1010), .WR_CYCLES(WRC)) uut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .nvm_busy(nvm_busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // reference model of the commit window, compared every clock (R6, R5)
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (arm_cnt != arm_seen) begin
                arm_seen = arm_cnt;
                left = WRC;
            end
            chk(nvm_busy == (left > 0), "R6 busy window", int'(nvm_busy), int'(left > 0));
            if (left > 0) left--;
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic bitc(input logic b, output logic r);
        m_sda = b; tick(2); m_scl = 1'b1; tick(2);
        r = sda_bus; tick(2); m_scl = 1'b0; tick(2);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(2); m_scl = 1'b1; tick(2);
        m_sda = 1'b0; tick(2); m_scl = 1'b0; tick(2);
    endtask

    task automatic bus_stop(input bit commit);
        m_sda = 1'b0; tick(2); m_scl = 1'b1; tick(2); m_sda = 1'b1;
        @(posedge clk); #1;
        if (commit) arm_cnt++;
        tick(2);
    endtask

    task automatic wbyte(input logic [7:0] d, output bit ack);
        logic r;
        for (int i = 7; i >= 0; i--) bitc(d[i], r);
        bitc(1'b1, r);
        ack = !r;
    endtask

    task automatic rbyte(input bit mack, output logic [7:0] d);
        logic r;
        d = '0;
        for (int i = 0; i < 8; i++) begin bitc(1'b1, r); d = {d[6:0], r}; end
        bitc(!mack, r);
    endtask

    task automatic rd_seq(input logic [7:0] a, input int n, input string req);
        bit ack; logic [7:0] d;
        bus_start();
        wbyte(CW, ack);  chk(ack, "R3 ctrl ack", ack, 1);
        wbyte(a, ack);   chk(ack, "R3 word address ack", ack, 1);
        bus_start();
        wbyte(CR, ack);  chk(ack, "R9 read ctrl ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            rbyte(i != n - 1, d);
            chk(d == mdl[8'(a + i)], req, d, mdl[8'(a + i)]);
        end
        bus_stop(0);
    endtask

    task automatic page_wr(input logic [7:0] a, input int n, input logic [7:0] seed);
        bit ack; logic [7:0] d;
        bus_start();
        wbyte(CW, ack);  chk(ack, "R2 ctrl accepted", ack, 1);
        wbyte(a, ack);   chk(ack, "R3 word address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            d = 8'(seed + 8'(i * 7));
            wbyte(d, ack);
            chk(ack, "R4 data ack", ack, 1);
            if (n == 16) mdl[{a[7:4], 4'(a[3:0] + 4'(i))}] = d;
        end
    endtask

    initial begin
        bit ack;
        for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
        tick(5); rst = 1'b0; tick(2);
        chk(sda_oe == 1'b0, "R10 sda_oe after reset", sda_oe, 0);
        chk(nvm_busy == 1'b0, "R10 busy after reset", nvm_busy, 0);
        rd_seq(8'h00, 2, "R10 erased read");

        // wrong control code, then following byte also ignored
        bus_start();
        wbyte(8'h30, ack); chk(!ack, "R2 wrong code nack", ack, 0);
        wbyte(8'h00, ack); chk(!ack, "R2 ignored after nack", ack, 0);
        bus_stop(0);
        // non-zero block number
        bus_start();
        wbyte(8'hA4, ack); chk(!ack, "R2 block nack", ack, 0);
        bus_stop(0);

        // full page write at page 3 offset 5, with poll during busy
        page_wr(8'h35, 16, 8'h11);
        bus_stop(1);
        bus_start();
        wbyte(CW, ack); chk(!ack, "R7 nack while busy", ack, 0);
        bus_stop(0);
        tick(WRC);
        rd_seq(8'h30, 20, "R9 R8 readback across page");

        // short write: no commit
        page_wr(8'h52, 5, 8'h40);
        bus_stop(0);
        tick(50);
        rd_seq(8'h52, 2, "R5 short write unchanged");

        // seventeenth byte refused, page still committed
        page_wr(8'h7C, 16, 8'h80);
        wbyte(8'h99, ack); chk(!ack, "R4 17th byte nack", ack, 0);
        bus_stop(1);
        tick(WRC + 10);
        rd_seq(8'h70, 16, "R4 R1 wrapped page");

        // dropped write via repeated start
        page_wr(8'h90, 3, 8'h20);
        bus_start();
        wbyte(CR, ack); chk(ack, "R8 read after repeated start", ack, 1);
        begin
            logic [7:0] d;
            rbyte(1'b0, d);
            chk(d == mdl[8'h93], "R8 no commit", d, mdl[8'h93]);
        end
        bus_stop(0);
        tick(20);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule